// File: doc/BRIEF.md
# Exception Entry and Return Unit

This block keeps the machine mode word of a simple in-order core together with two save registers: one for the resume address and one for a copy of the mode bits. When the core takes an exception, it presents a take request, the handler offset for that exception type and the address of the instruction that would have run next. In a single clock edge the unit saves that address and a selected subset of the mode bits. It also rewrites the mode word bit by bit and issues a fetch redirect to the handler.

A return request does the reverse. The mode word is reloaded from the mode save register, and fetch is redirected to the saved address. Software can read the three registers at any time and write them through a register-move port. Prioritising between exception causes, flushing the pipeline and the translation that the mode bits control are all handled outside this block.

Bit numbers in this document follow big-endian order. Bit n of a 32-bit word is vector index 31-n, so bit 0 is the most significant bit.

Top module: `exc_entry_unit`

## Requirements
- R1: After reset, the mode word and both save registers read as zero, and `redirect_o` is low.
- R2: On a take, save register 0 is loaded with `next_pc_i`.
- R3: On a take, save register 1 receives the prior mode word's bits 16–23, 25–27, 30 and 31 at the same positions. All of its other bits become zero.
- R4: On a take, bits 15 (exception endian), 19 (machine check enable) and 25 (vector prefix) of the mode word keep their values. Bit 31 (endian) takes the prior value of bit 15. Every other mode bit becomes zero, including bit 16 (external enable).
- R5: The edge that samples a take raises `redirect_o` for exactly one cycle, with `target_o` = {prefix, offset}. The prefix is 12'hFFF when mode bit 25 was set before the take and 12'h000 otherwise; the offset is `take_off_i`. `redirect_o` is low in any cycle that follows an edge with no take and no return.
- R6: A return, with no take in the same cycle, loads the mode word from save register 1 with reserved bits forced to zero. It also raises `redirect_o` for one cycle with `target_o` equal to save register 0.
- R7: If a take and a return are requested in the same cycle, only the take is performed, and the return is discarded.
- R8: Register select codes are 0 for the mode word, 1 for save register 0, 2 for save register 1 and 3 for none (reads zero). `sw_rdata_o` shows the selected register combinationally. Only bits 13, 15–23, 25–27, 30 and 31 of the mode word are implemented; the rest read as zero.
- R9: A software write in the same cycle as a take or a return has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| take_i | input | 1 | Exception take request |
| take_off_i | input | 20 | Handler offset for the exception type |
| next_pc_i | input | 32 | Address of the instruction that would run next |
| ret_i | input | 1 | Return-from-exception request |
| sw_we_i | input | 1 | Software register write strobe |
| sw_sel_i | input | 2 | Register select |
| sw_wdata_i | input | 32 | Software write data |
| sw_rdata_o | output | 32 | Selected register contents |
| redirect_o | output | 1 | Fetch redirect pulse |
| target_o | output | 32 | Redirect address |
| mode_o | output | 32 | Current mode word |

## Verification
A corrupted mode bit shows up on `mode_o` on the very next cycle. It also surfaces indirectly one entry later, in save register 1, and one return later, when the restored word is wrong. A wrong vector prefix or save address shows up at `target_o` in the cycle after the take or return that uses it. Precedence faults, where a return beats a take or a software write beats either, leave save register 0 or the mode word with the wrong value, which the register read port exposes at once.

// File: rtl/exc_entry_unit.sv
module exc_entry_unit #(
  parameter int OFS_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take_i,
  input  logic [OFS_W-1:0] take_off_i,
  input  logic [31:0]      next_pc_i,
  input  logic             ret_i,
  input  logic             sw_we_i,
  input  logic [1:0]       sw_sel_i,
  input  logic [31:0]      sw_wdata_i,
  output logic [31:0]      sw_rdata_o,
  output logic             redirect_o,
  output logic [31:0]      target_o,
  output logic [31:0]      mode_o
);
  localparam int PFX_W = 32 - OFS_W;

  function automatic logic [31:0] bb(input int n);
    return 32'h8000_0000 >> n;
  endfunction

  localparam logic [31:0] B_POW = bb(13);
  localparam logic [31:0] B_XLE = bb(15);
  localparam logic [31:0] B_EE  = bb(16);
  localparam logic [31:0] B_MCE = bb(19);
  localparam logic [31:0] B_PFX = bb(25);
  localparam logic [31:0] B_LE  = bb(31);
  localparam logic [31:0] SAVE_LD = bb(16) | bb(17) | bb(18) | bb(19) | bb(20) | bb(21) |
                                    bb(22) | bb(23) | bb(25) | bb(26) | bb(27) | bb(30) | bb(31);
  localparam logic [31:0] MODE_IMPL = SAVE_LD | B_POW | B_XLE;
  localparam logic [31:0] KEEP = B_XLE | B_MCE | B_PFX;

  localparam logic [1:0] SEL_MODE = 2'd0;
  localparam logic [1:0] SEL_SV0  = 2'd1;
  localparam logic [1:0] SEL_SV1  = 2'd2;

  logic [31:0] mode_q, sv0_q, sv1_q, tgt_q;
  logic        redir_q;

  wire [31:0] entry_mode = (mode_q & KEEP) | ((mode_q & B_XLE) != 0 ? B_LE : 32'h0);
  wire [PFX_W-1:0] pfx = (mode_q & B_PFX) != 0 ? {PFX_W{1'b1}} : {PFX_W{1'b0}};
  wire [31:0] entry_tgt = {pfx, take_off_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      sv0_q   <= '0;
      sv1_q   <= '0;
      tgt_q   <= '0;
      redir_q <= 1'b0;
    end else begin
      redir_q <= take_i | ret_i;
      if (take_i) begin
        sv0_q  <= next_pc_i;
        sv1_q  <= mode_q & SAVE_LD;
        mode_q <= entry_mode;
        tgt_q  <= entry_tgt;
      end else if (ret_i) begin
        mode_q <= sv1_q & MODE_IMPL;
        tgt_q  <= sv0_q;
      end else if (sw_we_i) begin
        case (sw_sel_i)
          SEL_MODE: mode_q <= sw_wdata_i & MODE_IMPL;
          SEL_SV0:  sv0_q  <= sw_wdata_i;
          SEL_SV1:  sv1_q  <= sw_wdata_i;
          default:  ;
        endcase
      end
    end
  end

  always_comb begin
    case (sw_sel_i)
      SEL_MODE: sw_rdata_o = mode_q;
      SEL_SV0:  sw_rdata_o = sv0_q;
      SEL_SV1:  sw_rdata_o = sv1_q;
      default:  sw_rdata_o = '0;
    endcase
  end

  assign redirect_o = redir_q;
  assign target_o   = tgt_q;
  assign mode_o     = mode_q;

  p_save0_r2: assert property (@(posedge clk) disable iff (!rst_n)
    take_i |=> sv0_q == $past(next_pc_i));

  p_save1_r3: assert property (@(posedge clk) disable iff (!rst_n)
    take_i |=> (sv1_q & ~SAVE_LD) == 32'h0);

  p_mode_r4: assert property (@(posedge clk) disable iff (!rst_n)
    take_i |=> (mode_o & ~(KEEP | B_LE)) == 32'h0 && (mode_o & B_EE) == 32'h0);

  p_redir_r5: assert property (@(posedge clk) disable iff (!rst_n)
    take_i |=> redirect_o && target_o[OFS_W-1:0] == $past(take_off_i));

  p_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(take_i || ret_i) |=> !redirect_o);

  p_return_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_i && !take_i) |=> redirect_o && target_o == $past(sv0_q) &&
                           mode_o == ($past(sv1_q) & MODE_IMPL));

  p_take_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && ret_i) |=> sv0_q == $past(next_pc_i));

  p_sw_blocked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_we_i && ret_i && !take_i && sw_sel_i == SEL_SV0) |=> $stable(sv0_q));
endmodule

// File: tb/exc_entry_unit_tb.sv
`timescale 1ns/1ps
module exc_entry_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        take_i = 1'b0;
  logic [19:0] take_off_i = '0;
  logic [31:0] next_pc_i = '0;
  logic        ret_i = 1'b0;
  logic        sw_we_i = 1'b0;
  logic [1:0]  sw_sel_i = '0;
  logic [31:0] sw_wdata_i = '0;
  logic [31:0] sw_rdata_o, target_o, mode_o;
  logic        redirect_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [31:0] exp_q[$];

  always #2.5 clk = ~clk;

  exc_entry_unit dut_i (
    .clk(clk), .rst_n(rst_n), .take_i(take_i), .take_off_i(take_off_i),
    .next_pc_i(next_pc_i), .ret_i(ret_i), .sw_we_i(sw_we_i), .sw_sel_i(sw_sel_i),
    .sw_wdata_i(sw_wdata_i), .sw_rdata_o(sw_rdata_o), .redirect_o(redirect_o),
    .target_o(target_o), .mode_o(mode_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && redirect_o) begin
      if (exp_q.size() == 0) begin
        checks++;
        errors++;
        $display("FAIL R5: actual redirect %h expected none", target_o);
      end else begin
        check("R5/R6 redirect target", target_o, exp_q.pop_front());
      end
    end
  end

  task automatic sw_write(input logic [1:0] sel, input logic [31:0] d);
    @(posedge clk); #1;
    sw_we_i = 1'b1; sw_sel_i = sel; sw_wdata_i = d;
    @(posedge clk); #1;
    sw_we_i = 1'b0;
  endtask

  task automatic sw_read(input logic [1:0] sel, output logic [31:0] d);
    @(negedge clk);
    sw_sel_i = sel;
    #0.5 d = sw_rdata_o;
  endtask

  task automatic op(input bit tk, input bit rt, input logic [19:0] off,
                    input logic [31:0] pc, input logic [31:0] exp_tgt,
                    input bit wr, input logic [1:0] sel, input logic [31:0] d);
    @(posedge clk); #1;
    take_i = tk; ret_i = rt; take_off_i = off; next_pc_i = pc;
    sw_we_i = wr; sw_sel_i = sel; sw_wdata_i = d;
    exp_q.push_back(exp_tgt);
    @(posedge clk); #1;
    take_i = 1'b0; ret_i = 1'b0; sw_we_i = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 5000 && !done; i++) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    sw_read(2'd0, r); check("R1 mode", r, 32'h0);
    sw_read(2'd1, r); check("R1 save0", r, 32'h0);
    sw_read(2'd2, r); check("R1 save1", r, 32'h0);
    check("R1 redirect", {31'h0, redirect_o}, 32'h0);
    // R8 implemented bits and select 3
    sw_write(2'd0, 32'hFFFF_FFFF);
    sw_read(2'd0, r); check("R8 mode mask", r, 32'h0005_FF73);
    sw_write(2'd3, 32'h1111_1111);
    sw_read(2'd3, r); check("R8 sel3 reads zero", r, 32'h0);
    sw_write(2'd1, 32'h1234_5678);
    sw_read(2'd1, r); check("R8 save0 write", r, 32'h1234_5678);
    // take with prefix set
    op(1, 0, 20'h00500, 32'h0000_2000, 32'hFFF0_0500, 0, 0, 0);
    sw_read(2'd1, r); check("R2 save0", r, 32'h0000_2000);
    sw_read(2'd2, r); check("R3 save1", r, 32'h0000_FF73);
    check("R4 mode after take", mode_o, 32'h0001_1041);
    // R6 return
    op(0, 1, 20'h0, 32'h0, 32'h0000_2000, 0, 0, 0);
    check("R6 mode restored", mode_o, 32'h0000_FF73);
    // R6 return masks reserved bits
    sw_write(2'd2, 32'hFFFF_FFFF);
    sw_write(2'd1, 32'h0000_4444);
    op(0, 1, 20'h0, 32'h0, 32'h0000_4444, 0, 0, 0);
    check("R6 reserved masked", mode_o, 32'h0005_FF73);
    // R5 prefix zero
    sw_write(2'd0, 32'h0);
    op(1, 0, 20'h00900, 32'h0000_1000, 32'h0000_0900, 0, 0, 0);
    check("R4 all cleared", mode_o, 32'h0);
    sw_read(2'd2, r); check("R3 save1 zero", r, 32'h0);
    // R4 LE copies exception endian
    sw_write(2'd0, 32'h0001_0000);
    op(1, 0, 20'h00700, 32'h0000_1004, 32'h0000_0700, 0, 0, 0);
    check("R4 LE from ILE", mode_o, 32'h0001_0001);
    // R4 EE and PR cleared, ME kept
    sw_write(2'd0, 32'h0000_D000);
    op(1, 0, 20'h00500, 32'h0000_1008, 32'h0000_0500, 0, 0, 0);
    check("R4 ME kept EE cleared", mode_o, 32'h0000_1000);
    // R7 take beats return
    sw_write(2'd1, 32'hABCD_0000);
    op(1, 1, 20'h00500, 32'h0000_3000, 32'h0000_0500, 0, 0, 0);
    sw_read(2'd1, r); check("R7 save0 from take", r, 32'h0000_3000);
    // R9 sw write during take ignored
    op(1, 0, 20'h00500, 32'h0000_3100, 32'h0000_0500, 1, 2'd1, 32'hDEAD_BEEF);
    sw_read(2'd1, r); check("R9 save0 write blocked by take", r, 32'h0000_3100);
    // R9 sw write during return ignored
    sw_write(2'd2, 32'h0000_0040);
    op(0, 1, 20'h0, 32'h0, 32'h0000_3100, 1, 2'd0, 32'h0001_0000);
    check("R9 mode write blocked by return", mode_o, 32'h0000_0040);
    repeat (3) @(negedge clk);
    check("R5 no extra redirects", exp_q.size(), 32'd0);
    check("R5 redirect idle", {31'h0, redirect_o}, 32'h0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule